// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block turns four external interrupt pins into four pending flags for an interrupt controller. Every pin first goes through a two-flop synchronizer. A further register keeps the previous synchronized sample, and edges are found by comparing that sample with the current one. Channels 0 and 1 are active-low. Each has a mode bit that selects one of two behaviours. In level mode the flag follows the pin directly. In edge mode a falling edge latches the flag, and the controller's acknowledge clears it. Channels 2 and 3 respond to edges only. A polarity bit on each of them selects whether a rising or a falling edge sets the flag, and only a software clear removes it.

Software can set or clear any latched flag with one-cycle write pulses. When a set and a clear arrive in the same cycle, the set wins. The controller pulses the acknowledge for a channel in the cycle it takes that channel's vector. Bit n of every per-channel vector belongs to channel n.

Top module: `xint_cond`

## Requirements
- R1: While rst_ni is low, and after reset is released with all pins high, every bit of pend_o is 0. The synchronizer and previous-sample registers reset to 1.
- R2: Level mode applies to channel 0 or 1 when edge_mode_i[n]=0. In level mode pend_o[n] is the inverse of pin_i[n] and follows it with a latency of two clocks.
- R3: In level mode, ack_i[n], sw_set_i[n] and sw_clr_i[n] have no effect on pend_o[n]. The internal latched flag is held cleared, so a switch to edge mode starts with pend_o[n]=0.
- R4: Edge mode applies to channel 0 or 1 when edge_mode_i[n]=1. In edge mode a high-to-low change on pin_i[n] sets pend_o[n] three clocks after the pin changes. A low-to-high change neither sets nor clears the flag.
- R5: In edge mode, a one-cycle pulse on ack_i[n] for channel 0 or 1 clears pend_o[n] at the next clock.
- R6: For any channel whose flag is latched, a pulse on sw_set_i[n] sets pend_o[n] at the next clock, and a pulse on sw_clr_i[n] clears it at the next clock.
- R7: Channel 2+k sets its flag on a rising edge when rise_pol_i[k]=1 and on a falling edge when rise_pol_i[k]=0. An edge of the other direction leaves the flag unchanged. The flag appears three clocks after the pin change.
- R8: If a set event (a pin edge or sw_set_i) and a clear (ack_i or sw_clr_i) occur in the same cycle, the flag ends up set.
- R9: ack_i[2] and ack_i[3] have no effect. The flags of channels 2 and 3 clear only through sw_clr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 4 | Raw external interrupt pins, bit n = channel n |
| edge_mode_i | input | 2 | Sensing mode for channels 0..1: 1 = falling edge, 0 = level (active low) |
| rise_pol_i | input | 2 | Edge polarity for channels 2..3 (bit k = channel 2+k): 1 = rising, 0 = falling |
| ack_i | input | 4 | Vector-taken pulse from the interrupt controller |
| sw_set_i | input | 4 | Software set pulse per channel |
| sw_clr_i | input | 4 | Software clear pulse per channel |
| pend_o | output | 4 | Pending flags |

## Verification
The hardest situation to produce from the ports is the one where a pin edge and a clear land in the same clock. The edge only counts as a set event two clocks after the pin moves, so the bench first latches the flag with a software set. It then drops the pin and asserts the acknowledge exactly two cycles later, so that both events fall on the same edge, and checks that the flag survives. The bench uses the same three-clock latency counting to check each channel on the cycle just before its flag may rise. It sweeps both polarities of channels 2 and 3 against both edge directions.

// File: rtl/xint_pkg.sv
package xint_pkg;
  typedef enum logic {SENSE_LEVEL = 1'b0, SENSE_EDGE = 1'b1} sense_e;
  typedef enum logic {POL_FALL = 1'b0, POL_RISE = 1'b1} pol_e;
  localparam int unsigned SYNC_DEPTH = 2;
endpackage

// File: rtl/xint_sync.sv
module xint_sync #(
  parameter int unsigned STAGES = xint_pkg::SYNC_DEPTH
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] stg_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q <= '1;
    else         stg_q <= {stg_q[STAGES-2:0], pin_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign level_o = stg_q[STAGES-1];
  assign prev_o  = prev_q;

  // R4
  prev_pipe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prev_o == $past(level_o));
endmodule

// File: rtl/xint_al_chan.sv
module xint_al_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_mode_i,
  input  logic level_i,
  input  logic prev_i,
  input  logic ack_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  import xint_pkg::*;

  logic flag_q, fall_ev, set_ev, clr_ev, is_edge;

  assign is_edge = (sense_e'(edge_mode_i) == SENSE_EDGE);
  assign fall_ev = prev_i & ~level_i;
  assign set_ev  = is_edge & (fall_ev | sw_set_i);
  assign clr_ev  = ack_i | sw_clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_q <= 1'b0;
    else if (!is_edge) flag_q <= 1'b0;
    else if (set_ev)  flag_q <= 1'b1;
    else if (clr_ev)  flag_q <= 1'b0;
  end

  assign pend_o = is_edge ? flag_q : ~level_i;

  // R5
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_edge && ack_i && !fall_ev && !sw_set_i) |=> !flag_q);
  // R8
  al_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_edge && (fall_ev || sw_set_i)) |=> flag_q);
endmodule

// File: rtl/xint_pol_chan.sv
module xint_pol_chan (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_pol_i,
  input  logic level_i,
  input  logic prev_i,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  output logic pend_o
);
  import xint_pkg::*;

  logic flag_q, edge_ev, set_ev;

  always_comb begin
    if (pol_e'(rise_pol_i) == POL_RISE) edge_ev = ~prev_i & level_i;
    else                                edge_ev = prev_i & ~level_i;
  end

  assign set_ev = edge_ev | sw_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flag_q <= 1'b0;
    else if (set_ev)   flag_q <= 1'b1;
    else if (sw_clr_i) flag_q <= 1'b0;
  end

  assign pend_o = flag_q;

  // R8
  pol_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_ev |=> pend_o);
endmodule

// File: rtl/xint_cond.sv
module xint_cond #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned NUM_AL = 2,
  parameter int unsigned SYNC_STAGES = xint_pkg::SYNC_DEPTH,
  localparam int unsigned NUM_PO = NUM_CH - NUM_AL
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic [NUM_AL-1:0] edge_mode_i,
  input  logic [NUM_PO-1:0] rise_pol_i,
  input  logic [NUM_CH-1:0] ack_i,
  input  logic [NUM_CH-1:0] sw_set_i,
  input  logic [NUM_CH-1:0] sw_clr_i,
  output logic [NUM_CH-1:0] pend_o
);
  logic [NUM_CH-1:0] lvl, prv;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    xint_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (pin_i[c]),
      .level_o(lvl[c]),
      .prev_o (prv[c])
    );

    if (c < NUM_AL) begin : g_al
      xint_al_chan u_chan (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .edge_mode_i(edge_mode_i[c]),
        .level_i    (lvl[c]),
        .prev_i     (prv[c]),
        .ack_i      (ack_i[c]),
        .sw_set_i   (sw_set_i[c]),
        .sw_clr_i   (sw_clr_i[c]),
        .pend_o     (pend_o[c])
      );
    end else begin : g_po
      xint_pol_chan u_chan (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rise_pol_i(rise_pol_i[c-NUM_AL]),
        .level_i   (lvl[c]),
        .prev_i    (prv[c]),
        .sw_set_i  (sw_set_i[c]),
        .sw_clr_i  (sw_clr_i[c]),
        .pend_o    (pend_o[c])
      );

      // R9
      ack_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o[c] && !sw_clr_i[c]) |=> pend_o[c]);
    end
  end
endmodule

// File: tb/xint_cond_bench.sv
module xint_cond_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] pin_i = 4'hF;
  logic [1:0] edge_mode_i = 2'b00;
  logic [1:0] rise_pol_i = 2'b00;
  logic [3:0] ack_i = '0, sw_set_i = '0, sw_clr_i = '0;
  logic [3:0] pend_o;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  xint_cond u_xint_cond (.*);

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input int ch, input logic exp);
    checks++;
    if (pend_o[ch] !== exp) begin
      errors++;
      $display("FAIL %s ch%0d: pend=%b expected %b", req, ch, pend_o[ch], exp);
    end
  endtask

  task automatic pulse(input logic [3:0] ack, input logic [3:0] set, input logic [3:0] clr);
    ack_i = ack; sw_set_i = set; sw_clr_i = clr;
    step(1);
    ack_i = '0; sw_set_i = '0; sw_clr_i = '0;
  endtask

  initial begin
    step(1);
    for (int c = 0; c < 4; c++) chk("R1", c, 1'b0);
    step(2);
    rst_ni = 1'b1;
    step(3);
    for (int c = 0; c < 4; c++) chk("R1", c, 1'b0);

    // level mode, channels 0/1
    for (int c = 0; c < 2; c++) begin
      pin_i[c] = 1'b0;
      step(1); chk("R2", c, 1'b0);
      step(1); chk("R2", c, 1'b1);
      pulse(4'(1 << c), 4'h0, 4'(1 << c));
      chk("R3", c, 1'b1);
      pin_i[c] = 1'b1;
      step(2); chk("R2", c, 1'b0);
      pulse(4'h0, 4'(1 << c), 4'h0);
      chk("R3", c, 1'b0);
    end

    // edge mode, channels 0/1
    edge_mode_i = 2'b11;
    step(1);
    for (int c = 0; c < 2; c++) begin
      chk("R3", c, 1'b0);
      pin_i[c] = 1'b0;
      step(2); chk("R4", c, 1'b0);
      step(1); chk("R4", c, 1'b1);
      pin_i[c] = 1'b1;
      step(3); chk("R4", c, 1'b1);
      pulse(4'(1 << c), 4'h0, 4'h0);
      chk("R5", c, 1'b0);
      pulse(4'h0, 4'(1 << c), 4'h0);
      chk("R6", c, 1'b1);
      pin_i[c] = 1'b0;
      step(2);
      pulse(4'(1 << c), 4'h0, 4'h0);
      chk("R8", c, 1'b1);
      pulse(4'(1 << c), 4'h0, 4'h0);
      chk("R5", c, 1'b0);
      pin_i[c] = 1'b1;
      step(3); chk("R4", c, 1'b0);
      pulse(4'h0, 4'(1 << c), 4'(1 << c));
      chk("R8", c, 1'b1);
      pulse(4'h0, 4'h0, 4'(1 << c));
      chk("R6", c, 1'b0);
    end

    // polarity channels 2/3
    for (int c = 2; c < 4; c++) begin
      for (int pol = 0; pol < 2; pol++) begin
        rise_pol_i[c-2] = pol[0];
        step(1);
        pin_i[c] = 1'b0;
        step(2); chk("R7", c, 1'b0);
        step(1); chk("R7", c, pol == 0);
        pulse(4'h0, 4'h0, 4'(1 << c));
        chk("R6", c, 1'b0);
        pin_i[c] = 1'b1;
        step(3); chk("R7", c, pol == 1);
        pulse(4'h0, 4'(1 << c), 4'h0);
        pulse(4'(1 << c), 4'h0, 4'h0);
        chk("R9", c, 1'b1);
        pulse(4'h0, 4'(1 << c), 4'(1 << c));
        chk("R8", c, 1'b1);
        pulse(4'h0, 4'h0, 4'(1 << c));
        chk("R6", c, 1'b0);
      end
    end

    // back to level mode: latched state dropped, pin followed
    edge_mode_i = 2'b00;
    pin_i[1:0] = 2'b01;
    step(3);
    chk("R2", 0, 1'b0);
    chk("R2", 1, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule